// File: doc/BRIEF.md
# Video Sync Timing Measurement Unit

This block watches an incoming video stream on three pins (horizontal sync, vertical sync and data enable) and measures the length of every interval of the raster. Along a line it measures sync width, back porch, active span and front porch, in clocks. Down a frame it measures the same four intervals, counted in lines. A line opens on the rising edge of the normalised horizontal sync, and a frame opens on a line whose start finds the normalised vertical sync newly high. The three pins pass through a two-flop synchroniser into the block clock. Each pin clock counts as one pixel clock, so the pixel clock and the register-bus clock are the same clock here.

Software reaches the block through a simple 32-bit register port. A write takes one cycle with `bus_wr` high. A read is combinational from `bus_addr`. Polarity, enable, interrupt enable and the update mode live in a control word. When a newly latched result differs from the value it replaces, the block sets a per-field change flag, which software clears by writing one to it. A watchdog counts bus clocks while horizontal sync stays low and raises a loss flag when the programmed limit is exceeded. Control and status are plain pins; the block has no streaming interface.

Top module: `vid_timing_meas`

## Requirements
- R1: After reset these registers read as shown. Change flags (0x00) read 0. Results (0x04–0x20) read 0. Control (0x24) reads 0. Trigger mask (0x28) reads 0xFF. Timeout limit (0x2C) reads 0x1FFF. Status (0x30) reads 0. The `irq` output is 0.
- R2: The horizontal results are read at these offsets, all in clocks. Sync width at 0x14 counts clocks with sync high. Back porch at 0x18 counts clocks from the sync fall to the first data-enable clock. Active span at 0x1C counts clocks with data enable high. Front porch at 0x20 counts clocks from the end of data enable to the next sync rise.
- R3: The vertical results count lines. Sync at 0x04 counts lines that start with vertical sync high. Back porch at 0x08 counts lines without data enable that come before the first active line. Active at 0x0C counts lines containing any data-enable clock. Front porch at 0x10 counts lines without data enable that come after the active lines.
- R4: Control bit 0 makes horizontal sync active-low and control bit 1 makes vertical sync active-low. Either bit inverts its pin before measurement, so inverted pins give the same results.
- R5: Control bit 4 selects the horizontal update mode. With bit 4 at 0, the horizontal results are taken from the last line of the frame that had data enable, and they are stored when the frame closes. With bit 4 at 1, the horizontal results are stored at every line end, blank lines included. The vertical results are always stored once per frame.
- R6: Each result field has a flag in register 0x00 and a trigger bit in register 0x28, at the same position in both. Bits 0–3 cover vertical sync, back porch, active and front porch. Bits 4–7 cover horizontal sync, back porch, active and front porch. A flag sets when its field is stored with a new, different value while its trigger bit is 1. Storing an unchanged value sets no flag. Writing 1 to a flag bit clears it.
- R7: `irq` is high exactly when control bit 3 is 1 and at least one flag is set whose trigger bit is 1.
- R8: Status bit 1 is set once the first complete frame after enable (control bit 2) has been measured. Clearing control bit 2 clears status bit 1 by the next clock.
- R9: Status bit 0 is set when the normalised horizontal sync stays low for more than the timeout limit in consecutive clocks. It stays low for a low period of exactly the limit. It clears once sync goes high.
- R10: A write of 0 to the timeout limit register is ignored. A non-zero write is stored.
- R11: Writes to the result registers and to the status register are ignored. Reads of unmapped or unaligned offsets return 0.
- R12: While control bit 2 is 0, video activity on the pins leaves every result register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block and register clock; one pixel per clock |
| rst_n | input | 1 | asynchronous active-low reset |
| vid_hsync | input | 1 | horizontal sync pin, polarity set by control bit 0 |
| vid_vsync | input | 1 | vertical sync pin, polarity set by control bit 1 |
| vid_de | input | 1 | data enable pin, active high |
| bus_wr | input | 1 | write strobe, one write per high cycle |
| bus_addr | input | AW (8) | byte offset for reads and writes |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational from `bus_addr` |
| irq | output | 1 | interrupt request |

## Verification
The three video pins reach the measuring logic through two synchroniser flops. A line's counts are registered one clock after the synchronised sync rise, and the frame stage adds one more clock. So a result register settles about five clocks after the sync pin rises on the line that closes the interval, and the bench waits eight idle clocks before reading any result. Register writes, flag clears and control changes take effect at the write edge. Their effect on `bus_rdata` and `irq` is sampled just after the following falling edge. The watchdog flag follows the pin by about three clocks. The bench therefore polls status on every clock across the whole low period and several clocks beyond it, and never samples at one single cycle.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
  localparam int unsigned NFIELD = 8;

  localparam logic [7:0] A_FLAGS = 8'h00;
  localparam logic [7:0] A_RES0  = 8'h04;
  localparam logic [7:0] A_CTRL  = 8'h24;
  localparam logic [7:0] A_TRIG  = 8'h28;
  localparam logic [7:0] A_TMO   = 8'h2C;
  localparam logic [7:0] A_STAT  = 8'h30;

  localparam int CB_HPOL = 0;
  localparam int CB_VPOL = 1;
  localparam int CB_EN   = 2;
  localparam int CB_IRQ  = 3;
  localparam int CB_LINE = 4;

  // segment of a line (in clocks) or of a frame (in lines); value = field index
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;

  function automatic seg_e seg_of(input logic in_sync, input logic in_act,
                                  input logic act_seen);
    if (in_sync) return SEG_SYNC;
    if (in_act) return SEG_ACT;
    if (act_seen) return SEG_FRONT;
    return SEG_BACK;
  endfunction
endpackage

// File: rtl/vtm_sync2.sv
module vtm_sync2 #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] inv,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2 ^ inv;
endmodule

// File: rtl/vtm_line_stage.sv
module vtm_line_stage
  import vtm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  hs,
  input  logic                  vs,
  input  logic                  de,
  output logic                  line_done,
  output logic                  line_had_de,
  output logic                  line_vs,
  output logic                  next_vs,
  output logic [3:0][CNT_W-1:0] seg_len
);
  logic hs_d, armed, seen_de, cur_vs;
  logic [3:0][CNT_W-1:0] cnt;
  seg_e seg;

  always_comb seg = seg_of(hs, de, seen_de);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_d <= 1'b0; armed <= 1'b0; seen_de <= 1'b0; cur_vs <= 1'b0;
      cnt <= '0; seg_len <= '0; line_done <= 1'b0;
      line_had_de <= 1'b0; line_vs <= 1'b0; next_vs <= 1'b0;
    end else if (!en) begin
      hs_d <= 1'b0; armed <= 1'b0; seen_de <= 1'b0; cur_vs <= 1'b0;
      cnt <= '0; line_done <= 1'b0;
    end else begin
      hs_d      <= hs;
      line_done <= 1'b0;
      if (hs && !hs_d) begin
        if (armed) begin
          line_done   <= 1'b1;
          seg_len     <= cnt;
          line_had_de <= seen_de;
          line_vs     <= cur_vs;
          next_vs     <= vs;
        end
        armed         <= 1'b1;
        cur_vs        <= vs;
        seen_de       <= 1'b0;
        cnt           <= '0;
        cnt[SEG_SYNC] <= CNT_W'(1);
      end else begin
        cnt[seg] <= cnt[seg] + 1'b1;
        if (seg == SEG_ACT) seen_de <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vtm_frame_stage.sv
module vtm_frame_stage
  import vtm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  line_done,
  input  logic                  line_had_de,
  input  logic                  line_vs,
  input  logic                  next_vs,
  output logic                  frame_done,
  output logic [3:0][CNT_W-1:0] seg_len
);
  logic armed, seen_act;
  logic [3:0][CNT_W-1:0] cnt, cnt_n;
  seg_e seg;

  always_comb begin
    seg        = seg_of(line_vs, line_had_de, seen_act);
    cnt_n      = cnt;
    cnt_n[seg] = cnt[seg] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; seen_act <= 1'b0; cnt <= '0;
      frame_done <= 1'b0; seg_len <= '0;
    end else if (!en) begin
      armed <= 1'b0; seen_act <= 1'b0; cnt <= '0; frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (line_done) begin
        if (next_vs && !line_vs) begin
          if (armed) begin
            frame_done <= 1'b1;
            seg_len    <= cnt_n;
          end
          armed    <= 1'b1;
          seen_act <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= cnt_n;
          if (seg == SEG_ACT) seen_act <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vtm_hs_watchdog.sv
module vtm_hs_watchdog #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hs,
  input  logic [TMO_W-1:0] limit,
  output logic             timed_out
);
  logic [TMO_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0; timed_out <= 1'b0;
    end else if (!en || hs) begin
      low_cnt <= '0; timed_out <= 1'b0;
    end else if (low_cnt >= limit) begin
      timed_out <= 1'b1;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vid_timing_meas.sv
module vid_timing_meas
  import vtm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TMO_W = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vid_hsync,
  input  logic          vid_vsync,
  input  logic          vid_de,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam logic [TMO_W-1:0] TMO_RST = TMO_W'(32'h1FFF);

  logic [4:0]            ctrl_q;
  logic [NFIELD-1:0]     trig_q, flags_q, flag_set, lat;
  logic [TMO_W-1:0]      tmo_q;
  logic                  init_done_q, tmo_flag;
  logic [NFIELD-1:0][CNT_W-1:0] res_q, nv;
  logic [3:0][CNT_W-1:0] l_len, f_len, h_shadow;
  logic [2:0]            pins_n;
  logic                  hs_n, vs_n, de_n;
  logic                  line_done, line_had_de, line_vs, next_vs, frame_done;
  logic                  unused_bits;

  assign unused_bits = ^bus_wdata[31:8];

  vtm_sync2 #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({vid_de, vid_vsync, vid_hsync}),
    .inv({1'b0, ctrl_q[CB_VPOL], ctrl_q[CB_HPOL]}),
    .q(pins_n));
  assign {de_n, vs_n, hs_n} = pins_n;

  vtm_line_stage #(.CNT_W(CNT_W)) u_line (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[CB_EN]),
    .hs(hs_n), .vs(vs_n), .de(de_n),
    .line_done(line_done), .line_had_de(line_had_de),
    .line_vs(line_vs), .next_vs(next_vs), .seg_len(l_len));

  vtm_frame_stage #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[CB_EN]),
    .line_done(line_done), .line_had_de(line_had_de),
    .line_vs(line_vs), .next_vs(next_vs),
    .frame_done(frame_done), .seg_len(f_len));

  vtm_hs_watchdog #(.TMO_W(TMO_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[CB_EN]), .hs(hs_n),
    .limit(tmo_q), .timed_out(tmo_flag));

  // result fields: 0..3 vertical, 4..7 horizontal
  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    if (i < 4) begin : g_v
      assign lat[i] = frame_done;
      assign nv[i]  = f_len[i];
    end else begin : g_h
      assign lat[i] = ctrl_q[CB_LINE] ? line_done : frame_done;
      assign nv[i]  = ctrl_q[CB_LINE] ? l_len[i-4] : h_shadow[i-4];
    end
    assign flag_set[i] = lat[i] && (nv[i] != res_q[i]) && trig_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q[i] <= '0;
      else if (lat[i]) res_q[i] <= nv[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; trig_q <= '1; tmo_q <= TMO_RST; flags_q <= '0;
      init_done_q <= 1'b0; h_shadow <= '0;
    end else begin
      if (bus_wr && bus_addr == AW'(A_CTRL)) ctrl_q <= bus_wdata[4:0];
      if (bus_wr && bus_addr == AW'(A_TRIG)) trig_q <= bus_wdata[NFIELD-1:0];
      if (bus_wr && bus_addr == AW'(A_TMO) && bus_wdata[TMO_W-1:0] != '0)
        tmo_q <= bus_wdata[TMO_W-1:0];
      flags_q <= (flags_q & ~((bus_wr && bus_addr == AW'(A_FLAGS)) ?
                              bus_wdata[NFIELD-1:0] : '0)) | flag_set;
      if (!ctrl_q[CB_EN])  init_done_q <= 1'b0;
      else if (frame_done) init_done_q <= 1'b1;
      if (line_done && line_had_de) h_shadow <= l_len;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_FLAGS)) bus_rdata = 32'(flags_q);
    if (bus_addr == AW'(A_CTRL))  bus_rdata = 32'(ctrl_q);
    if (bus_addr == AW'(A_TRIG))  bus_rdata = 32'(trig_q);
    if (bus_addr == AW'(A_TMO))   bus_rdata = 32'(tmo_q);
    if (bus_addr == AW'(A_STAT))  bus_rdata = {30'd0, init_done_q, tmo_flag};
    for (int k = 0; k < NFIELD; k++)
      if (bus_addr == AW'(A_RES0 + 4 * k)) bus_rdata = 32'(res_q[k]);
  end

  assign irq = ctrl_q[CB_IRQ] && |(flags_q & trig_q);
endmodule

// File: rtl/vid_timing_meas_chk.sv
module vid_timing_meas_chk #(
  parameter int TMO_W = 16,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             irq,
  input logic             en,
  input logic             irq_en,
  input logic             init_done,
  input logic             tmo_flag,
  input logic             hs_n,
  input logic [7:0]       flags,
  input logic [7:0]       trig,
  input logic [TMO_W-1:0] tmo_val
);
  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R8
  init_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !init_done);

  // R9
  tmo_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> !$past(hs_n));

  // R6
  flag_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags) & ~$past(trig)) == 8'h00);

  // R10
  tmo_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_val != '0);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > AW'(8'h30) || bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'd0);
endmodule

bind vid_timing_meas vid_timing_meas_chk #(.TMO_W(TMO_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq(irq), .en(ctrl_q[2]), .irq_en(ctrl_q[3]), .init_done(init_done_q),
  .tmo_flag(tmo_flag), .hs_n(hs_n), .flags(flags_q), .trig(trig_q),
  .tmo_val(tmo_q));

// File: tb/sim_vid_timing_meas.sv
module sim_vid_timing_meas;
  typedef int tim_t[8];  // vsync, vbp, vact, vfp, hsync, hbp, hact, hfp

  logic clk = 1'b0, rst_n = 1'b0;
  logic vid_hsync = 1'b0, vid_vsync = 1'b0, vid_de = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic irq;
  logic pol_h = 1'b0, pol_v = 1'b0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  vid_timing_meas u0 (.clk(clk), .rst_n(rst_n), .vid_hsync(vid_hsync),
    .vid_vsync(vid_vsync), .vid_de(vid_de), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic pix(logic h, logic v, logic d);
    @(negedge clk); vid_hsync = h ^ pol_h; vid_vsync = v ^ pol_v; vid_de = d;
  endtask

  task automatic run(tim_t t, logic [4:0] ctl);
    int vl, hl;
    vl = t[0] + t[1] + t[2] + t[3];
    hl = t[4] + t[5] + t[6] + t[7];
    wr(8'h24, 32'(ctl & 5'b11011));
    pol_h = ctl[0]; pol_v = ctl[1];
    repeat (4) pix(1'b0, 1'b0, 1'b0);
    wr(8'h24, 32'(ctl));
    repeat (2) pix(1'b0, 1'b0, 1'b0);
    for (int f = 0; f < 3; f++)
      for (int l = 0; l < vl; l++)
        for (int p = 0; p < hl; p++)
          pix(p < t[4], l < t[0],
              (l >= t[0] + t[1]) && (l < t[0] + t[1] + t[2]) &&
              (p >= t[4] + t[5]) && (p < t[4] + t[5] + t[6]));
    repeat (2) pix(1'b1, 1'b1, 1'b0);
    repeat (8) pix(1'b0, 1'b0, 1'b0);
  endtask

  task automatic check_res(string tag, tim_t e);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(8'(4 + 4 * k), v);
      chk($sformatf("%s field %0d", tag, k), v, 32'(e[k]));
    end
  endtask

  task automatic hs_probe(int low_n, output bit seen);
    seen = 1'b0;
    bus_addr = 8'h30;
    repeat (6) pix(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < low_n; i++) begin
      pix(1'b0, 1'b0, 1'b0); #1 if (bus_rdata[0]) seen = 1'b1;
    end
    for (int i = 0; i < 8; i++) begin
      pix(1'b1, 1'b0, 1'b0); #1 if (bus_rdata[0]) seen = 1'b1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    tim_t ta, tb_, tc, hmode, zero8;
    logic [31:0] v;
    bit seen;
    ta = '{1, 2, 3, 2, 2, 3, 5, 4};
    tb_ = '{2, 1, 4, 1, 4, 1, 7, 2};
    tc = '{3, 3, 2, 3, 1, 2, 3, 1};
    hmode = '{1, 2, 3, 2, 2, 12, 0, 0};
    zero8 = '{0, 0, 0, 0, 0, 0, 0, 0};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 flags", v, 32'h0);
    check_res("R1 results", zero8);
    rd(8'h24, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h28, v); chk("R1 trig", v, 32'hFF);
    rd(8'h2C, v); chk("R1 tmo", v, 32'h1FFF);
    rd(8'h30, v); chk("R1 status", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 R3 frame mode, config A
    run(ta, 5'b01100);
    check_res("R2 R3 cfg A", ta);
    rd(8'h00, v); chk("R6 flags first frame", v, 32'hFF);
    chk("R7 irq on", 32'(irq), 32'h1);
    rd(8'h30, v); chk("R8 init done", v, 32'h2);

    // R6 write-one-to-clear
    wr(8'h00, 32'h0F);
    rd(8'h00, v); chk("R6 partial clear", v, 32'hF0);
    wr(8'h00, 32'hF0);
    rd(8'h00, v); chk("R6 full clear", v, 32'h0);
    chk("R7 irq off", 32'(irq), 32'h0);

    // R6 unchanged values set no flag
    run(ta, 5'b01100);
    rd(8'h00, v); chk("R6 unchanged", v, 32'h0);

    // R6 trigger mask, config B
    wr(8'h28, 32'h0F);
    run(tb_, 5'b01100);
    check_res("R2 R3 cfg B", tb_);
    rd(8'h00, v); chk("R6 masked", v, 32'h0F);
    wr(8'h00, 32'hFF);
    wr(8'h28, 32'hFF);

    // R4 inverted polarity, interrupt disabled
    run(tc, 5'b00111);
    check_res("R4 cfg C inverted", tc);
    rd(8'h00, v); chk("R6 flags cfg C", v, 32'hFF);
    chk("R7 irq gated", 32'(irq), 32'h0);
    wr(8'h24, 32'h0F);
    rd(8'h00, v); chk("R7 irq enabled", 32'(irq), 32'h1);
    wr(8'h00, 32'hFF);

    // R5 per-line update: last stored line is blank (14 clocks)
    run(ta, 5'b10100);
    check_res("R5 line mode", hmode);

    // R8 R12 disabled
    run(tb_, 5'b00000);
    rd(8'h30, v); chk("R8 init cleared", v, 32'h0);
    check_res("R12 disabled", hmode);

    // R11 read-only and unmapped
    wr(8'h1C, 32'hDEAD);
    wr(8'h30, 32'h3);
    rd(8'h1C, v); chk("R11 result write ignored", v, 32'h0);
    rd(8'h30, v); chk("R11 status write ignored", v, 32'h0);
    rd(8'h34, v); chk("R11 unmapped 34", v, 32'h0);
    rd(8'h05, v); chk("R11 unaligned 05", v, 32'h0);
    rd(8'hFC, v); chk("R11 unmapped FC", v, 32'h0);

    // R10 timeout limit
    wr(8'h2C, 32'd10);
    rd(8'h2C, v); chk("R10 tmo write", v, 32'd10);
    wr(8'h2C, 32'd0);
    rd(8'h2C, v); chk("R10 zero ignored", v, 32'd10);

    // R9 watchdog boundary
    pol_h = 1'b0; pol_v = 1'b0;
    wr(8'h24, 32'h04);
    hs_probe(10, seen); chk("R9 low for limit", 32'(seen), 32'h0);
    hs_probe(11, seen); chk("R9 low for limit+1", 32'(seen), 32'h1);
    repeat (6) pix(1'b1, 1'b0, 1'b0);
    repeat (30) pix(1'b0, 1'b0, 1'b0);
    #1 chk("R9 long low", 32'(bus_rdata[0]), 32'h1);
    repeat (6) pix(1'b1, 1'b0, 1'b0);
    #1 chk("R9 cleared by sync", 32'(bus_rdata[0]), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule